// File: doc/BRIEF.md
# Sampled-Entropy Random Number Collector

This block is a register-mapped random number peripheral. A raw, asynchronous entropy bit from an external ring oscillator is brought into the clock domain through a two-flop synchronizer. The block then captures it once every programmed number of clock cycles and packs the captures into up to eight 32-bit result words. Software programs the capture period, enables the source, and chooses a ring speed and a result length of 64, 128, 192 or 256 bits. It then sets a start bit and polls that bit until the hardware clears it. The result words are then read back.

The control register takes masked writes. The upper half of the written word chooses which of the lower sixteen bits are updated, so software can change one field without a read-modify-write. A separate soft reset register returns the whole block to its reset state.

Top module: `entropy_collector`

## Requirements
- R1: After reset, the control register (0x400), the sample-count register (0x404) and every result word read 0, and `ring_speed` is 0.
- R2: A write to the control register at 0x400 changes bit n of [15:0] only when write-data bit n+16 is 1. The control fields are: bit 0 start, bit 1 enable, [3:2] ring speed, [5:4] length code. Bits [15:6] always read 0.
- R3: `ring_speed` always shows control bits [3:2], and changes on the clock edge that writes them.
- R4: A start request is ignored when the resulting enable bit is 0, and start then reads 0. A start request made during a collection does not restart that collection.
- R5: Suppose the start bit is accepted on clock edge E0 and the effective period is P. Start reads 1 up to and including edge E0+N*P-1, and reads 0 after edge E0+N*P, where N is 64*(length code+1).
- R6: The sample-count register at 0x404 holds the written 32-bit value. Captures happen every P cycles, where P equals that value, except that a value of 0 gives P=1.
- R7: Capture k of a collection (k from 0) is shifted in at the LSB of result word k/32, and words are read at 0x410+4*w. A captured bit is the raw input as the synchronizer saw it two clock edges before the capture.
- R8: Accepting a start clears all result words. Word w reads 0 whenever w is at least 2*(current length code+1).
- R9: Any control write that leaves enable at 0 clears start and aborts the collection. A later write of enable alone does not resume it. A write of 0xFFFF0000 stops the block this way.
- R10: Writing 1 in bit 0 of the soft reset register at 0x004 returns all state to the R1 values on that clock edge. That register reads 0.
- R11: Reads from any other offset, including unaligned ones, return 0. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| raw_bit | input | 1 | Asynchronous raw entropy bit |
| ring_speed | output | 2 | Oscillator ring speed select |

## Verification
Collections use four length codes, each paired with a different period. The periods are 0 (read as 1), 3, 4 and 5, so length decoding, period counting and the zero-period rule each affect a distinct completion edge. Each collection feeds a known bit pattern timed to the capture edges. An all-ones run uses every word. Asymmetric hex patterns then show fill order, the LSB shift direction and word boundaries, and a shorter run after a long one shows the clearing of stale words. A start-bit read one cycle before and one cycle after the expected end pins the count exactly. Aborts, start without enable, masked field updates and soft reset are each checked through the register readback and the `ring_speed` pin.

// File: rtl/entc_pkg.sv
package entc_pkg;

    localparam int ADDR_W = 12;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFF_SRST = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_DATA = 12'h410;

    // Control fields, MSB first: length code, ring speed, enable, start
    typedef struct packed {
        logic [1:0] len;
        logic [1:0] speed;
        logic       enable;
        logic       start;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SRST,
        RG_CTRL,
        RG_CNT,
        RG_DATA
    } region_e;

    function automatic ctrl_t masked_update(input ctrl_t old_v,
                                            input logic [CTRL_W-1:0] val,
                                            input logic [CTRL_W-1:0] mask);
        return ctrl_t'((old_v & ~mask) | (val & mask));
    endfunction

    function automatic region_e decode_region(input logic [ADDR_W-1:0] a,
                                              input int nwords);
        if (a == OFF_SRST) return RG_SRST;
        if (a == OFF_CTRL) return RG_CTRL;
        if (a == OFF_CNT)  return RG_CNT;
        if (a[1:0] == 2'b00 && int'(a) >= int'(OFF_DATA) &&
            int'(a) < int'(OFF_DATA) + 4 * nwords)
            return RG_DATA;
        return RG_NONE;
    endfunction

endpackage

// File: rtl/entc_sync.sv
module entc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/entc_ctrl.sv
module entc_ctrl
    import entc_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int IDX_W    = 8,
    parameter int SEG_BITS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_val,
    input  logic [CTRL_W-1:0] wr_mask,
    input  logic [CNT_W-1:0]  period_cfg,
    output ctrl_t             ctrl_o,
    output logic              capture_o,
    output logic              clear_o,
    output logic [IDX_W-1:0]  bit_idx_o,
    output logic [CNT_W-1:0]  timer_o,
    output logic [CNT_W-1:0]  period_o
);
    ctrl_t            ctrl_q, ctrl_n, wr_res;
    logic [CNT_W-1:0] timer_q, timer_n, period_q, period_n, eff_period;
    logic [IDX_W-1:0] idx_q, idx_n, last_idx;
    logic [1:0]       run_len_q, run_len_n;
    logic             capture, clear;

    always_comb begin
        eff_period = (period_cfg == '0) ? CNT_W'(1) : period_cfg;
        last_idx   = IDX_W'((int'(run_len_q) + 1) * SEG_BITS - 1);
        capture    = ctrl_q.start && (timer_q == '0);
        wr_res     = masked_update(ctrl_q, wr_val, wr_mask);

        ctrl_n    = ctrl_q;
        timer_n   = timer_q;
        period_n  = period_q;
        idx_n     = idx_q;
        run_len_n = run_len_q;
        clear     = 1'b0;

        // Collection stepping
        if (ctrl_q.start) begin
            if (capture) begin
                idx_n   = idx_q + 1'b1;
                timer_n = period_q - 1'b1;
                if (idx_q == last_idx) ctrl_n.start = 1'b0;
            end else begin
                timer_n = timer_q - 1'b1;
            end
        end

        // Register writes override stepping where they conflict
        if (wr_en) begin
            ctrl_n.len    = wr_res.len;
            ctrl_n.speed  = wr_res.speed;
            ctrl_n.enable = wr_res.enable;
            if (!wr_res.enable) begin
                ctrl_n.start = 1'b0;
            end else if (wr_mask[0] && wr_val[0] && !ctrl_q.start) begin
                ctrl_n.start = 1'b1;
                timer_n      = eff_period - 1'b1;
                period_n     = eff_period;
                idx_n        = '0;
                run_len_n    = wr_res.len;
                clear        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            timer_q   <= '0;
            period_q  <= CNT_W'(1);
            idx_q     <= '0;
            run_len_q <= '0;
        end else begin
            ctrl_q    <= ctrl_n;
            timer_q   <= timer_n;
            period_q  <= period_n;
            idx_q     <= idx_n;
            run_len_q <= run_len_n;
        end
    end

    assign ctrl_o    = ctrl_q;
    assign capture_o = capture;
    assign clear_o   = clear;
    assign bit_idx_o = idx_q;
    assign timer_o   = timer_q;
    assign period_o  = period_q;
endmodule

// File: rtl/entc_pack.sv
module entc_pack
    import entc_pkg::*;
#(
    parameter int NWORDS = 8,
    parameter int IDX_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    capture,
    input  logic [IDX_W-1:0]        bit_idx,
    input  logic                    sample,
    output logic [NWORDS*BUS_W-1:0] words_flat
);
    localparam int LSB_W = $clog2(BUS_W);
    localparam int SEL_W = IDX_W - LSB_W;

    logic [SEL_W-1:0] sel;
    assign sel = bit_idx[IDX_W-1:LSB_W];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [BUS_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst || clear)
                word_q <= '0;
            else if (capture && sel == SEL_W'(w))
                word_q <= {word_q[BUS_W-2:0], sample};
        end
        assign words_flat[w*BUS_W +: BUS_W] = word_q;
    end
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
    import entc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int NWORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              raw_bit,
    output logic [1:0]        ring_speed
);
    localparam int TOTAL_BITS = NWORDS * BUS_W;
    localparam int IDX_W      = $clog2(TOTAL_BITS);
    localparam int SEG_BITS   = TOTAL_BITS / 4;
    localparam int SEG_WORDS  = NWORDS / 4;
    localparam int WIDX_W     = $clog2(NWORDS);

    region_e                 region;
    logic                    srst_hit, core_rst;
    logic [CNT_W-1:0]        cnt_q, timer_w, period_w;
    ctrl_t                   ctrl_q;
    logic                    capture, clear, sample;
    logic [IDX_W-1:0]        bit_idx;
    logic [NWORDS*BUS_W-1:0] words_flat;
    logic [WIDX_W-1:0]       widx;
    int                      valid_words;

    assign region   = decode_region(bus_addr, NWORDS);
    assign srst_hit = bus_we && region == RG_SRST && bus_wdata[0];
    assign core_rst = rst || srst_hit;

    always_ff @(posedge clk) begin
        if (core_rst)                      cnt_q <= '0;
        else if (bus_we && region == RG_CNT) cnt_q <= bus_wdata[CNT_W-1:0];
    end

    entc_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (core_rst),
        .d_async (raw_bit),
        .d_sync  (sample)
    );

    entc_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W), .SEG_BITS(SEG_BITS)) u_ctrl (
        .clk        (clk),
        .rst        (core_rst),
        .wr_en      (bus_we && region == RG_CTRL),
        .wr_val     (bus_wdata[CTRL_W-1:0]),
        .wr_mask    (bus_wdata[16 +: CTRL_W]),
        .period_cfg (cnt_q),
        .ctrl_o     (ctrl_q),
        .capture_o  (capture),
        .clear_o    (clear),
        .bit_idx_o  (bit_idx),
        .timer_o    (timer_w),
        .period_o   (period_w)
    );

    entc_pack #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_pack (
        .clk        (clk),
        .rst        (core_rst),
        .clear      (clear),
        .capture    (capture),
        .bit_idx    (bit_idx),
        .sample     (sample),
        .words_flat (words_flat)
    );

    assign ring_speed  = ctrl_q.speed;
    assign widx        = WIDX_W'((bus_addr - OFF_DATA) >> 2);
    assign valid_words = (int'(ctrl_q.len) + 1) * SEG_WORDS;

    always_comb begin
        bus_rdata = '0;
        unique case (region)
            RG_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            RG_CNT:  bus_rdata[CNT_W-1:0]  = cnt_q;
            RG_DATA: if (int'(widx) < valid_words)
                         bus_rdata = words_flat[int'(widx)*BUS_W +: BUS_W];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/entc_checker.sv
module entc_checker
    import entc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [1:0]        ring_speed,
    input logic              ctrl_start,
    input logic              ctrl_enable,
    input logic [1:0]        ctrl_len,
    input logic [CNT_W-1:0]  timer,
    input logic [CNT_W-1:0]  period
);
    // R3: a fully masked speed write appears on the pin next cycle
    p_speed_follows_write_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_CTRL && bus_wdata[19:18] == 2'b11)
        |=> (ring_speed == $past(bus_wdata[3:2])));

    // R2: unmasked length bits keep their value
    p_len_masked_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_CTRL && bus_wdata[21:20] == 2'b00)
        |=> $stable(ctrl_len));

    // R4: a running collection always has the source enabled
    p_start_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl_start |-> ctrl_enable);

    // R9: the stop write clears start and enable
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_CTRL && bus_wdata == 32'hFFFF_0000)
        |=> (!ctrl_start && !ctrl_enable));

    // R10: soft reset returns control state to zero
    p_softreset_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_SRST && bus_wdata[0])
        |=> (!ctrl_start && !ctrl_enable && ctrl_len == 2'b00 && ring_speed == 2'b00));

    // R6: the period timer stays below a nonzero latched period
    p_timer_bound_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl_start |-> (period != '0 && timer < period));

    // R11: an unmapped offset reads zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 12'h008) |-> (bus_rdata == 32'h0));
endmodule

bind entropy_collector entc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ring_speed  (ring_speed),
    .ctrl_start  (ctrl_q.start),
    .ctrl_enable (ctrl_q.enable),
    .ctrl_len    (ctrl_q.len),
    .timer       (timer_w),
    .period      (period_w)
);

// File: tb/test_entropy_collector.sv
module test_entropy_collector;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        raw_bit;
    logic [1:0]  ring_speed;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    entropy_collector i_entropy_collector (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .raw_bit    (raw_bit),
        .ring_speed (ring_speed)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset_r1();
        logic [31:0] v;
        bus_read(12'h400, v); check("R1 ctrl", v, 32'h0);
        bus_read(12'h404, v); check("R1 count", v, 32'h0);
        bus_read(12'h410, v); check("R1 word0", v, 32'h0);
        check("R1 ring_speed", {30'h0, ring_speed}, 32'h0);
    endtask

    task automatic t_masked_r2();
        logic [31:0] v;
        bus_write(12'h400, 32'h0033_0032);
        bus_read(12'h400, v); check("R2 len3+enable", v, 32'h32);
        bus_write(12'h400, 32'h0010_0000);
        bus_read(12'h400, v); check("R2 single bit4", v, 32'h22);
        bus_write(12'h400, 32'hFFC0_FFC0);
        bus_read(12'h400, v); check("R2 upper bits", v, 32'h22);
    endtask

    task automatic t_speed_r3();
        logic [31:0] v;
        bus_write(12'h400, 32'h000C_0008);
        check("R3 speed 2", {30'h0, ring_speed}, 32'h2);
        bus_read(12'h400, v); check("R3 ctrl", v, 32'h2A);
        bus_write(12'h400, 32'h0004_0004);
        check("R3 speed 3", {30'h0, ring_speed}, 32'h3);
        bus_write(12'h400, 32'hFFFF_0000);
        bus_read(12'h400, v); check("R9 stop clears", v, 32'h0);
    endtask

    task automatic t_no_enable_r4();
        logic [31:0] v;
        bus_write(12'h400, 32'h0001_0001);
        bus_read(12'h400, v); check("R4 start alone", v, 32'h0);
        bus_write(12'h400, 32'h0003_0001);
        repeat (3) @(negedge clk);
        bus_read(12'h400, v); check("R4 start enable0", v, 32'h0);
    endtask

    // Run one collection with pattern bit i = pat[255-i]
    task automatic collect_r5(input logic [1:0] len, input logic [31:0] cnt,
                              input logic [255:0] pat, input string tag);
        logic [31:0] v, exp;
        int n_bits, per, nw;
        n_bits = 64 * (int'(len) + 1);
        per    = (cnt == 0) ? 1 : int'(cnt);
        nw     = 2 * (int'(len) + 1);
        bus_write(12'h404, cnt);
        bus_write(12'h400, {16'h0032, 10'h0, len, 4'h2});
        raw_bit = pat[255];
        repeat (2) @(negedge clk);
        bus_write(12'h400, 32'h0001_0001);
        for (int i = 1; i < n_bits; i++) begin
            repeat (per) @(negedge clk);
            raw_bit = pat[255-i];
        end
        repeat (per - 1) @(negedge clk);
        bus_read(12'h400, v); check({"R5 busy at last-1 ", tag}, {31'h0, v[0]}, 32'h1);
        @(negedge clk);
        bus_read(12'h400, v); check({"R5 done ", tag}, {31'h0, v[0]}, 32'h0);
        for (int w = 0; w < 8; w++) begin
            exp = (w < nw) ? pat[255-32*w -: 32] : 32'h0;
            bus_read(12'(12'h410 + 4*w), v);
            check({"R7 R8 word ", tag}, v, exp);
        end
    endtask

    task automatic t_readmask_r8();
        logic [31:0] v;
        bus_write(12'h400, 32'h0030_0000);
        bus_read(12'h418, v); check("R8 word2 masked by len0", v, 32'h0);
        bus_read(12'h410, v); check("R8 word0 kept", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_softreset_r10();
        logic [31:0] v;
        bus_write(12'h404, 32'h0000_0055);
        bus_read(12'h404, v); check("R6 count readback", v, 32'h55);
        bus_write(12'h400, 32'h003E_003E);
        check("R3 speed set", {30'h0, ring_speed}, 32'h3);
        bus_write(12'h004, 32'h1);
        bus_read(12'h400, v); check("R10 ctrl", v, 32'h0);
        bus_read(12'h404, v); check("R10 count", v, 32'h0);
        bus_read(12'h410, v); check("R10 word0", v, 32'h0);
        bus_read(12'h004, v); check("R10 reg reads 0", v, 32'h0);
        check("R10 ring_speed", {30'h0, ring_speed}, 32'h0);
    endtask

    task automatic t_stop_r9();
        logic [31:0] v;
        bus_write(12'h404, 32'd100);
        bus_write(12'h400, 32'h0032_0002);
        bus_write(12'h400, 32'h0001_0001);
        repeat (10) @(negedge clk);
        bus_read(12'h400, v); check("R9 running", {31'h0, v[0]}, 32'h1);
        bus_write(12'h400, 32'hFFFF_0000);
        bus_read(12'h400, v); check("R9 stopped", v, 32'h0);
        repeat (300) @(negedge clk);
        bus_write(12'h400, 32'h0002_0002);
        bus_read(12'h400, v); check("R9 no resume", v, 32'h2);
    endtask

    task automatic t_unmapped_r11();
        logic [31:0] v;
        bus_read(12'h008, v); check("R11 0x008", v, 32'h0);
        bus_read(12'h430, v); check("R11 0x430", v, 32'h0);
        bus_read(12'h412, v); check("R11 unaligned", v, 32'h0);
        bus_write(12'h408, 32'hFFFF_FFFF);
        bus_read(12'h400, v); check("R11 ctrl untouched", v, 32'h2);
        bus_read(12'h404, v); check("R11 count untouched", v, 32'd100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R5 actual=timeout expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; raw_bit = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_r1();
        t_masked_r2();
        t_speed_r3();
        t_no_enable_r4();
        // R6: count 0 acts as period 1
        collect_r5(2'd3, 32'd0, {256{1'b1}}, "len3 p0");
        collect_r5(2'd0, 32'd4, {64'hA5C3_0F1E_9B27_D46C, 192'h0}, "len0 p4");
        collect_r5(2'd1, 32'd3, {128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h0}, "len1 p3");
        collect_r5(2'd2, 32'd5, {192'hDEAD_BEEF_1357_9BDF_8000_0001_2468_ACE0_F0F0_0F0F_3C3C_C3C3, 64'h0}, "len2 p5");
        t_readmask_r8();
        t_softreset_r10();
        t_stop_r9();
        t_unmapped_r11();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule